// File: doc/BRIEF.md
# SPI Controller Status Flag Unit

This block keeps the status flags of an SPI controller and shows them as one read-only 32-bit status word. Its inputs are one-cycle event pulses and level indications. The pulses come from the serializer (a received word loaded, a transmit word taken), from mode-fault detection, from enable and disable commands, from software accesses (transmit data write, receive data read, status read, DMA counter writes), and from the DMA engine. The DMA engine also drives level "counter is zero" indications for the current and next receive and transmit counters.

Each flag follows its own rule. Some are set by an event and cleared by a data read. Some are sticky until a status read. Some are sticky until a counter write. Two are plain level combinations of the counter-zero inputs. The transmit-empty flag also depends on the enable state.

The status word is a continuous view of the flag registers, so it needs no handshake. On the cycle a status read strobe is high, the word still shows the values from before the read. The clears take effect at that clock edge. Every event pulse is sampled on every clock and cannot be refused, so there is no back-pressure.

Top module: `spi_stat_flags`

## Requirements
- R1: Bit 0 (receive full) sets on a receive load and clears on a receive data read. If both happen in the same cycle, the flag is 1.
- R2: Bit 1 (transmit empty) is 0 after reset and while the unit is disabled. An enable command sets it to 1.
- R3: While enabled, a transmit data write clears bit 1 and a serializer take sets it. If both happen in the same cycle, bit 1 is 0.
- R4: Bit 2 (mode fault) sets on a mode-fault pulse and stays set until a status read. If both happen in the same cycle, the flag is 1.
- R5: Bit 3 (overrun) sets on a receive load while bit 0 is 1 and no receive data read happens in that cycle. It clears on a status read, and the set wins over the clear.
- R6: Bit 4 (end of receive) sets when the current receive counter-zero input rises. Bit 5 (end of transmit) does the same for the transmit counter. Each clears on a write to its counter, and the set wins over the clear.
- R7: Bit 6 is 1 exactly when both receive counter-zero inputs are 1, and bit 7 is 1 exactly when both transmit counter-zero inputs are 1, in the same cycle.
- R8: Bit 16 shows the enable state. Bits 8 to 15 and 17 to 31 read 0.
- R9: During the cycle of a status read, the word shows the flag values from before that read clears them.
- R10: A synchronous active-high reset clears every flag and the enable state. A disable command clears the enable state and wins over an enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Disable command pulse |
| ser_rx_load | input | 1 | Received word moved into the receive data register |
| ser_tx_take | input | 1 | Serializer took the pending transmit word |
| sw_tx_write | input | 1 | Software wrote the transmit data register |
| mode_fault | input | 1 | Mode fault detected |
| sw_rx_read | input | 1 | Software read the receive data register |
| sw_stat_read | input | 1 | Software read the status word |
| rx_cur_zero | input | 1 | Current receive DMA counter is zero (level) |
| rx_nxt_zero | input | 1 | Next receive DMA counter is zero (level) |
| tx_cur_zero | input | 1 | Current transmit DMA counter is zero (level) |
| tx_nxt_zero | input | 1 | Next transmit DMA counter is zero (level) |
| rx_cnt_write | input | 1 | Write to the receive DMA counter |
| tx_cnt_write | input | 1 | Write to the transmit DMA counter |
| stat_word | output | 32 | Status word |

## Verification
The bench aims at cycles where a set event and its clearing access arrive together. A design with the wrong priority would drop a mode fault, an overrun or an end-of-buffer event, or would leave transmit empty high after a new word was written. It checks that a receive load in the same cycle as a data read is not counted as an overrun, and that a counter that stays at zero after being written does not set its end flag again. It also checks that the status word seen during a read still carries the flags that the read is about to clear. A design that cleared too early would show zero. Finally it checks that transmit events are ignored while disabled, and that disable wins over enable.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W    = 32;
  localparam int B_RXFULL  = 0;
  localparam int B_TXEMPTY = 1;
  localparam int B_MODF    = 2;
  localparam int B_OVR     = 3;
  localparam int B_ENDRX   = 4;
  localparam int B_ENDTX   = 5;
  localparam int B_RXBUFF  = 6;
  localparam int B_TXBUFE  = 7;
  localparam int B_EN      = 16;
  localparam int NCH       = 2;   // DMA channels: 0 = receive, 1 = transmit
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // Set has priority over clear so no event is lost (R1, R4, R5, R6).
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/tx_enable_ctl.sv
module tx_enable_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic tx_write,
  input  logic tx_take,
  output logic en_o,
  output logic tx_empty_o
);
  logic en_next;

  always_comb begin
    en_next = en_o;
    if (cmd_enable)  en_next = 1'b1;
    if (cmd_disable) en_next = 1'b0;   // disable wins (R10)
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o       <= 1'b0;
      tx_empty_o <= 1'b0;
    end else begin
      en_o <= en_next;
      if (!en_next)                tx_empty_o <= 1'b0;   // R2
      else if (tx_write)           tx_empty_o <= 1'b0;   // R3: write wins
      else if (cmd_enable || tx_take) tx_empty_o <= 1'b1;
    end
  end

  assert_disabled_empty_R2: assert property (@(posedge clk) disable iff (rst)
    !en_o |-> !tx_empty_o);
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
    tx_write |=> !tx_empty_o);
  assert_disable_wins_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_disable |=> !en_o);
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!en_o && !tx_empty_o));
endmodule

// File: rtl/dma_end_track.sv
module dma_end_track (
  input  logic clk,
  input  logic rst,
  input  logic cur_zero,
  input  logic nxt_zero,
  input  logic cnt_write,
  output logic end_o,
  output logic buf_o
);
  logic cur_zero_d;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) cur_zero_d <= 1'b0;
    else     cur_zero_d <= cur_zero;
  end

  assign rise  = cur_zero && !cur_zero_d;
  assign buf_o = cur_zero && nxt_zero;     // R7

  sticky_flag end_flag_i (
    .clk(clk), .rst(rst), .set_i(rise), .clr_i(cnt_write), .q_o(end_o)
  );

  assert_end_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_write && !rise) |=> !end_o);
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              ser_rx_load,
  input  logic              ser_tx_take,
  input  logic              sw_tx_write,
  input  logic              mode_fault,
  input  logic              sw_rx_read,
  input  logic              sw_stat_read,
  input  logic              rx_cur_zero,
  input  logic              rx_nxt_zero,
  input  logic              tx_cur_zero,
  input  logic              tx_nxt_zero,
  input  logic              rx_cnt_write,
  input  logic              tx_cnt_write,
  output logic [STAT_W-1:0] stat_word
);
  logic en_q, tx_empty_q, rx_full_q, modf_q, ovr_q;
  logic ovr_set;
  logic [NCH-1:0] cz, nz, cw, end_q, buf_q;

  assign cz = {tx_cur_zero, rx_cur_zero};
  assign nz = {tx_nxt_zero, rx_nxt_zero};
  assign cw = {tx_cnt_write, rx_cnt_write};

  tx_enable_ctl tx_ctl_i (
    .clk(clk), .rst(rst), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .tx_write(sw_tx_write), .tx_take(ser_tx_take),
    .en_o(en_q), .tx_empty_o(tx_empty_q)
  );

  sticky_flag rx_full_i (
    .clk(clk), .rst(rst), .set_i(ser_rx_load), .clr_i(sw_rx_read), .q_o(rx_full_q)
  );

  sticky_flag modf_i (
    .clk(clk), .rst(rst), .set_i(mode_fault), .clr_i(sw_stat_read), .q_o(modf_q)
  );

  // Second load with no read of the receive register in between (R5).
  assign ovr_set = ser_rx_load && rx_full_q && !sw_rx_read;

  sticky_flag ovr_i (
    .clk(clk), .rst(rst), .set_i(ovr_set), .clr_i(sw_stat_read), .q_o(ovr_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_dma
    dma_end_track trk_i (
      .clk(clk), .rst(rst), .cur_zero(cz[g]), .nxt_zero(nz[g]),
      .cnt_write(cw[g]), .end_o(end_q[g]), .buf_o(buf_q[g])
    );
  end

  always_comb begin
    stat_word            = '0;
    stat_word[B_RXFULL]  = rx_full_q;
    stat_word[B_TXEMPTY] = tx_empty_q;
    stat_word[B_MODF]    = modf_q;
    stat_word[B_OVR]     = ovr_q;
    stat_word[B_ENDRX]   = end_q[0];
    stat_word[B_ENDTX]   = end_q[1];
    stat_word[B_RXBUFF]  = buf_q[0];
    stat_word[B_TXBUFE]  = buf_q[1];
    stat_word[B_EN]      = en_q;
  end

  assert_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_rx_load && rx_full_q && !sw_rx_read) |=> ovr_q);
  assert_no_ovr_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    (!ovr_q && sw_rx_read) |=> !ovr_q);
  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (sw_stat_read && !mode_fault) |=> !modf_q);
endmodule

// File: tb/spi_stat_flags_tb_top.sv
module spi_stat_flags_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic en, dis, rxl, txt, tdw, mf, rdd, rds, rcz, rnz, tcz, tnz, rcw, tcw;
  logic [31:0] stat_word;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  spi_stat_flags dut_i (
    .clk(clk), .rst(rst), .cmd_enable(en), .cmd_disable(dis),
    .ser_rx_load(rxl), .ser_tx_take(txt), .sw_tx_write(tdw), .mode_fault(mf),
    .sw_rx_read(rdd), .sw_stat_read(rds), .rx_cur_zero(rcz), .rx_nxt_zero(rnz),
    .tx_cur_zero(tcz), .tx_nxt_zero(tnz), .rx_cnt_write(rcw), .tx_cnt_write(tcw),
    .stat_word(stat_word)
  );

  // inputs: en dis rxl txt tdw mf rdd rds rcz rnz tcz tnz rcw tcw
  // expected: en(bit16) b7 b6 b5 b4 b3 b2 b1 b0
  localparam int NV = 28;
  localparam logic [22:0] VEC [NV] = '{
    {14'b00000000000000, 9'b0_0000_0000}, // idle
    {14'b10000000000000, 9'b1_0000_0010}, // R2 enable
    {14'b00001000000000, 9'b1_0000_0000}, // R3 write
    {14'b00010000000000, 9'b1_0000_0010}, // R3 take
    {14'b00011000000000, 9'b1_0000_0000}, // R3 write+take
    {14'b00010000000000, 9'b1_0000_0010}, // R3 take
    {14'b00100000000000, 9'b1_0000_0011}, // R1 load
    {14'b00100000000000, 9'b1_0000_1011}, // R5 overrun
    {14'b00000001000000, 9'b1_0000_0011}, // R5 status read clears
    {14'b00100010000000, 9'b1_0000_0011}, // R1 R5 load+read
    {14'b00000010000000, 9'b1_0000_0010}, // R1 read clears
    {14'b00000100000000, 9'b1_0000_0110}, // R4 fault
    {14'b00000101000000, 9'b1_0000_0110}, // R4 fault+status read
    {14'b00000001000000, 9'b1_0000_0010}, // R4 clear
    {14'b00000000100000, 9'b1_0001_0010}, // R6 endrx
    {14'b00000000110000, 9'b1_0101_0010}, // R7 rxbuff
    {14'b00000000110010, 9'b1_0100_0010}, // R6 write clears, no re-set
    {14'b00000000000000, 9'b1_0000_0010}, // R7
    {14'b00000000001100, 9'b1_1010_0010}, // R6 R7 tx side
    {14'b00000000000100, 9'b1_0010_0010}, // R7
    {14'b00000000001001, 9'b1_0010_0010}, // R6 set wins over write
    {14'b00000000000001, 9'b1_0000_0010}, // R6 clear
    {14'b01000000000000, 9'b0_0000_0000}, // R10 disable, R2
    {14'b00011000000000, 9'b0_0000_0000}, // R2 ignored while disabled
    {14'b11000000000000, 9'b0_0000_0000}, // R10 disable wins
    {14'b10000000000000, 9'b1_0000_0010}, // R2
    {14'b00100000000000, 9'b1_0000_0011}, // R1
    {14'b00100001000000, 9'b1_0000_1011}  // R5 set wins over status read
  };

  function automatic logic [31:0] expand(input logic [8:0] e);
    logic [31:0] w;
    w = '0;
    w[7:0] = e[7:0];
    w[16]  = e[8];
    return w;
  endfunction

  task automatic drive(input logic [13:0] v);
    {en, dis, rxl, txt, tdw, mf, rdd, rds, rcz, rnz, tcz, tnz, rcw, tcw} = v;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive('0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset state", stat_word, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][22:9]);
      @(posedge clk);
      #1;
      check($sformatf("R8 vector %0d", i), stat_word, expand(VEC[i][8:0]));
    end

    // R9: the word seen during a status read still holds pre-clear flags
    @(negedge clk);
    drive(14'b00000100000000);            // mode fault
    @(negedge clk);
    drive(14'b00000001000000);            // status read
    #1;
    check("R9 pre-clear value", stat_word, 32'h0001_000F);
    @(posedge clk);
    #1;
    check("R9 after read", stat_word, 32'h0001_0003);

    // R10: reset mid-run clears everything
    @(negedge clk);
    drive(14'b00100100001100);
    @(negedge clk);
    drive('0);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R10 reset clears", stat_word, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    // R6: counter already zero out of reset is a rise, once
    drive(14'b00000000100000);
    @(posedge clk);
    #1;
    check("R6 rise after reset", stat_word, 32'h0000_0010);
    @(negedge clk);
    drive(14'b00000000100010);
    @(posedge clk);
    #1;
    check("R6 held zero no re-set", stat_word, 32'h0);

    @(negedge clk);
    drive('0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule